// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a synchronous model of the command front end and the embedded operation sequencer of a NOR-style flash memory. A host issues single-cycle bus writes that carry a command code in the low data byte, an address and data. From these the controller decodes array-read, status-read, status-clear, word-program and block-erase requests. It runs program and erase operations for a fixed number of clock cycles. Either operation can be suspended and later resumed. While an operation runs, a ready/busy output is held low.

The controller samples two protection inputs when an operation is confirmed. The first reports whether the programming supply is valid. The second is an active-low protect pin that locks the two topmost (boot) blocks. A refused operation sets error flags in an 8-bit status register and leaves the array untouched. The storage is a small register array of uniform blocks. It resets to all ones, the erased state.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the bus reads the array in array mode, every word reads FFFFh, ry_by is 1, ry_by_hiz is 0, and the status register reads 80h.
- R2: A program is a setup write with code 40h or 10h, followed by a write that carries the target address and data. The stored word becomes its old value ANDed with the data, so programming can only clear bits.
- R3: From the edge that captures a confirmed program, ry_by is 0 and status bit 7 reads 0 for exactly PGM_CYC cycles, and ry_by then returns to 1.
- R4: An erase is a write of code 20h followed by D0h at any address inside the block. After ERS_CYC busy cycles, every word of that block reads FFFFh.
- R5: If the write after an erase setup is not D0h, status bits 5 and 4 are both set, the controller returns to ready and nothing is erased.
- R6: Code B0h written during a busy operation suspends it. ry_by_hiz becomes 1, status bit 6 (erase) or bit 2 (program) becomes 1, the target is still unchanged, and FFh allows other data to be read.
- R7: Code D0h written while an operation is suspended resumes it: ry_by_hiz returns to 0, ry_by goes to 0, and the operation completes with its normal result.
- R8: If vpp_ok is low when an operation is confirmed, status bit 3 is set together with bit 4 (program) or bit 5 (erase), and the array is unchanged.
- R9: With vpp_ok high and prot_n low, a program or erase aimed at one of the two highest blocks sets status bit 1 and the matching error bit, and is not performed. With prot_n high, that same block can be programmed.
- R10: Code 70h selects status mode, in which the bus reads {8'h00, status}. Code FFh selects array mode. The setup codes 40h, 10h and 20h also select status mode.
- R11: Code 50h clears status bits 5, 4, 3 and 1.
- R12: Any other code received while the controller is ready changes neither the read mode nor the array. Status bit 0 and the upper data byte read 0 in status mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | One-cycle bus write strobe |
| bus_addr | input | AW (5) | Word address for writes and reads |
| bus_wdata | input | DW (16) | Write data; command code in bits 7:0 |
| bus_rdata | output | DW (16) | Array word or {00h, status}, depending on the read mode |
| vpp_ok | input | 1 | Programming supply valid, sampled at confirm |
| prot_n | input | 1 | Low locks the two boot blocks |
| ry_by | output | 1 | Low while an operation is running |
| ry_by_hiz | output | 1 | High while an operation is suspended (output released) |

## Verification
A wrong sequencer state shows up on ry_by and ry_by_hiz within one cycle of the write that caused it, and bit 7 of a status read shows it in the same cycle. A wrong busy count shows up only at the end of the operation, as a ready edge that comes early or late, so the bench counts busy cycles exactly. A wrong protection decision or a corrupted array shows up only when a word is read back after the operation. For this reason every operation is followed by an array-mode read of the target word and of a word in a neighbouring block.

// File: rtl/fci_pkg.sv
package fci_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGM_SET,
        ST_ERS_SET,
        ST_PGM_RUN,
        ST_ERS_RUN,
        ST_PGM_SUSP,
        ST_ERS_SUSP
    } fci_state_e;

    localparam logic [7:0] CMD_PGM_A = 8'h40;
    localparam logic [7:0] CMD_PGM_B = 8'h10;
    localparam logic [7:0] CMD_ERS   = 8'h20;
    localparam logic [7:0] CMD_CONF  = 8'hD0;
    localparam logic [7:0] CMD_SUSP  = 8'hB0;
    localparam logic [7:0] CMD_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR   = 8'h50;
    localparam logic [7:0] CMD_ARRAY = 8'hFF;

    // status register layout, bit 7 down to bit 0
    typedef struct packed {
        logic rdy;
        logic ers_susp;
        logic ers_err;
        logic pgm_err;
        logic vpp_low;
        logic pgm_susp;
        logic lock_err;
        logic rsvd;
    } fci_status_t;

    function automatic logic is_running(fci_state_e s);
        return (s == ST_PGM_RUN) || (s == ST_ERS_RUN);
    endfunction

    function automatic logic is_suspended(fci_state_e s);
        return (s == ST_PGM_SUSP) || (s == ST_ERS_SUSP);
    endfunction

endpackage

// File: rtl/fci_lock.sv
module fci_lock #(
    parameter int NBLK  = 8,
    parameter int NBOOT = 2,
    localparam int BW   = $clog2(NBLK)
) (
    input  logic [BW-1:0] blk,
    input  logic          vpp_ok,
    input  logic          prot_n,
    output logic          vpp_fail,
    output logic          lock_fail
);
    localparam logic [BW-1:0] FIRST_BOOT = BW'(NBLK - NBOOT);

    always_comb begin
        vpp_fail  = !vpp_ok;
        lock_fail = vpp_ok && !prot_n && (blk >= FIRST_BOOT);
    end
endmodule

// File: rtl/fci_timer.sv
module fci_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] ld_val,
    input  logic          run,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= ld_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fci_array.sv
module fci_array #(
    parameter int AW  = 5,
    parameter int DW  = 16,
    parameter int BAW = 2,
    localparam int NW = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pgm_en,
    input  logic          ers_en,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdat,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdat
);
    logic [DW-1:0] mem [NW];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NW; i++) begin
            if (rst)
                mem[i] <= '1;
            else if (ers_en && ((i >> BAW) == int'(waddr[AW-1:BAW])))
                mem[i] <= '1;
            else if (pgm_en && (i == int'(waddr)))
                mem[i] <= mem[i] & wdat;
        end
    end

    assign rdat = mem[raddr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fci_pkg::*;
#(
    parameter int DW      = 16,
    parameter int NBLK    = 8,
    parameter int BAW     = 2,
    parameter int NBOOT   = 2,
    parameter int PGM_CYC = 6,
    parameter int ERS_CYC = 12,
    localparam int AW     = $clog2(NBLK) + BAW,
    localparam int CW     = $clog2(((PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          vpp_ok,
    input  logic          prot_n,
    output logic          ry_by,
    output logic          ry_by_hiz
);
    fci_state_e    state;
    logic          stat_mode;
    logic          ers_err_q, pgm_err_q, vpp_low_q, lock_err_q;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic [7:0]    code;
    logic          vpp_fail, lock_fail;
    logic          go_pgm, go_ers, susp_req, t_zero, t_run, commit;
    logic [DW-1:0] arr_rdat;
    fci_status_t   sr;

    assign code = bus_wdata[7:0];

    fci_lock #(.NBLK(NBLK), .NBOOT(NBOOT)) u_lock (
        .blk      (bus_addr[AW-1:BAW]),
        .vpp_ok   (vpp_ok),
        .prot_n   (prot_n),
        .vpp_fail (vpp_fail),
        .lock_fail(lock_fail)
    );

    always_comb begin
        go_pgm   = (state == ST_PGM_SET) && bus_we && !vpp_fail && !lock_fail;
        go_ers   = (state == ST_ERS_SET) && bus_we && (code == CMD_CONF) && !vpp_fail && !lock_fail;
        susp_req = is_running(state) && bus_we && (code == CMD_SUSP);
        t_run    = is_running(state) && !susp_req;
        commit   = t_run && t_zero;
    end

    fci_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (go_pgm || go_ers),
        .ld_val(go_ers ? CW'(ERS_CYC - 1) : CW'(PGM_CYC - 1)),
        .run   (t_run),
        .zero  (t_zero)
    );

    fci_array #(.AW(AW), .DW(DW), .BAW(BAW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .pgm_en(commit && (state == ST_PGM_RUN)),
        .ers_en(commit && (state == ST_ERS_RUN)),
        .waddr (op_addr),
        .wdat  (op_data),
        .raddr (bus_addr),
        .rdat  (arr_rdat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            stat_mode  <= 1'b0;
            ers_err_q  <= 1'b0;
            pgm_err_q  <= 1'b0;
            vpp_low_q  <= 1'b0;
            lock_err_q <= 1'b0;
            op_addr    <= '0;
            op_data    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (bus_we) begin
                    case (code)
                        CMD_PGM_A, CMD_PGM_B: begin state <= ST_PGM_SET; stat_mode <= 1'b1; end
                        CMD_ERS:   begin state <= ST_ERS_SET; stat_mode <= 1'b1; end
                        CMD_STAT:  stat_mode <= 1'b1;
                        CMD_ARRAY: stat_mode <= 1'b0;
                        CMD_CLR: begin
                            ers_err_q  <= 1'b0;
                            pgm_err_q  <= 1'b0;
                            vpp_low_q  <= 1'b0;
                            lock_err_q <= 1'b0;
                        end
                        default: ;
                    endcase
                end
                ST_PGM_SET: if (bus_we) begin
                    if (vpp_fail || lock_fail) begin
                        pgm_err_q  <= 1'b1;
                        vpp_low_q  <= vpp_low_q | vpp_fail;
                        lock_err_q <= lock_err_q | lock_fail;
                        state      <= ST_IDLE;
                    end else begin
                        op_addr <= bus_addr;
                        op_data <= bus_wdata;
                        state   <= ST_PGM_RUN;
                    end
                end
                ST_ERS_SET: if (bus_we) begin
                    if (code != CMD_CONF) begin
                        ers_err_q <= 1'b1;
                        pgm_err_q <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (vpp_fail || lock_fail) begin
                        ers_err_q  <= 1'b1;
                        vpp_low_q  <= vpp_low_q | vpp_fail;
                        lock_err_q <= lock_err_q | lock_fail;
                        state      <= ST_IDLE;
                    end else begin
                        op_addr <= bus_addr;
                        state   <= ST_ERS_RUN;
                    end
                end
                ST_PGM_RUN, ST_ERS_RUN: begin
                    if (susp_req)
                        state <= (state == ST_PGM_RUN) ? ST_PGM_SUSP : ST_ERS_SUSP;
                    else if (t_zero)
                        state <= ST_IDLE;
                end
                ST_PGM_SUSP, ST_ERS_SUSP: if (bus_we) begin
                    case (code)
                        CMD_CONF:  state <= (state == ST_PGM_SUSP) ? ST_PGM_RUN : ST_ERS_RUN;
                        CMD_ARRAY: stat_mode <= 1'b0;
                        CMD_STAT:  stat_mode <= 1'b1;
                        default: ;
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sr.rdy      = !is_running(state);
        sr.ers_susp = (state == ST_ERS_SUSP);
        sr.ers_err  = ers_err_q;
        sr.pgm_err  = pgm_err_q;
        sr.vpp_low  = vpp_low_q;
        sr.pgm_susp = (state == ST_PGM_SUSP);
        sr.lock_err = lock_err_q;
        sr.rsvd     = 1'b0;
        bus_rdata   = stat_mode ? {{(DW-8){1'b0}}, sr} : arr_rdat;
        ry_by       = !is_running(state);
        ry_by_hiz   = is_suspended(state);
    end
endmodule

// File: rtl/fci_checker.sv
module fci_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic [7:0]    code,
    input logic [DW-1:0] bus_rdata,
    input logic          stat_mode,
    input logic          ers_err_q,
    input logic          ry_by,
    input logic          ry_by_hiz
);
    AST_BUSY_NOT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !ry_by |-> !ry_by_hiz); // R3

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(ry_by) |-> $past(bus_we)); // R3

    AST_BUSY_STATUS_BIT: assert property (@(posedge clk) disable iff (rst)
        (stat_mode && !ry_by) |-> !bus_rdata[7]); // R3

    AST_SUSPEND_ON_B0: assert property (@(posedge clk) disable iff (rst)
        $rose(ry_by_hiz) |-> $past(bus_we && code == 8'hB0)); // R6

    AST_RESUME_ON_D0: assert property (@(posedge clk) disable iff (rst)
        $fell(ry_by_hiz) |-> $past(bus_we && code == 8'hD0)); // R7

    AST_ERASE_ERR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(ers_err_q) |-> $past(bus_we)); // R5

    AST_STATUS_FORMAT: assert property (@(posedge clk) disable iff (rst)
        stat_mode |-> (bus_rdata[DW-1:8] == '0 && !bus_rdata[0])); // R12
endmodule

bind flash_cmd_ctrl fci_checker #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .code     (bus_wdata[7:0]),
    .bus_rdata(bus_rdata),
    .stat_mode(stat_mode),
    .ers_err_q(ers_err_q),
    .ry_by    (ry_by),
    .ry_by_hiz(ry_by_hiz)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
    localparam int AW = 5;
    localparam int DW = 16;
    localparam int PGM_CYC = 6;
    localparam int ERS_CYC = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          vpp_ok = 1'b1;
    logic          prot_n = 1'b0;
    logic          ry_by, ry_by_hiz;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vpp_ok(vpp_ok),
        .prot_n(prot_n), .ry_by(ry_by), .ry_by_hiz(ry_by_hiz)
    );

    // {command, address, expected read data after the write}
    localparam logic [28:0] TBL [6] = '{
        {8'hFF, 5'd0,  16'hFFFF},  // R10 array mode
        {8'h70, 5'd0,  16'h0080},  // R10 status mode
        {8'h33, 5'd0,  16'h0080},  // R12 unknown code, stays in status
        {8'hFF, 5'd3,  16'hFFFF},  // R10
        {8'h5A, 5'd3,  16'hFFFF},  // R12 unknown code, stays in array
        {8'hC3, 5'd9,  16'hFFFF}   // R12
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ry_by && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic read_arr(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        bus_wr(a, 16'h00FF);
        check(req, bus_rdata, exp);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", bus_rdata, 16'hFFFF);
        check("R1 ry_by", {15'd0, ry_by}, 16'd1);
        check("R1 hiz", {15'd0, ry_by_hiz}, 16'd0);
        bus_wr(5'd0, 16'h0070);
        check("R1 status", bus_rdata, 16'h0080);

        for (int i = 0; i < 6; i++) begin
            bus_wr(TBL[i][20:16], {8'h00, TBL[i][28:21]});
            check("R10/R12 table", bus_rdata, TBL[i][15:0]);
        end

        // R2 R3 program with 40h
        bus_wr(5'd5, 16'h0040);
        bus_wr(5'd5, 16'h1234);
        check("R3 busy status", bus_rdata, 16'h0000);
        wait_ready(n);
        check("R3 busy cycles", 16'(n), 16'(PGM_CYC));
        check("R10 status after program", bus_rdata, 16'h0080);
        read_arr("R2 program", 5'd5, 16'h1234);
        // R2 program with 10h clears bits only
        bus_wr(5'd5, 16'h0010);
        bus_wr(5'd5, 16'hFF00);
        wait_ready(n);
        read_arr("R2 AND program", 5'd5, 16'h1200);

        // R4 erase block 1 via another address in it
        bus_wr(5'd4, 16'h0020);
        bus_wr(5'd6, 16'h00D0);
        check("R4 busy", {15'd0, ry_by}, 16'd0);
        wait_ready(n);
        check("R4 erase cycles", 16'(n), 16'(ERS_CYC));
        read_arr("R4 erased word", 5'd5, 16'hFFFF);

        // R5 improper erase sequence
        bus_wr(5'd4, 16'h0040);
        bus_wr(5'd4, 16'h0F0F);
        wait_ready(n);
        bus_wr(5'd4, 16'h0020);
        bus_wr(5'd4, 16'h0077);
        check("R5 status", bus_rdata, 16'h00B0);
        check("R5 ready", {15'd0, ry_by}, 16'd1);
        bus_wr(5'd4, 16'h0050);
        check("R11 clear", bus_rdata, 16'h0080);
        read_arr("R5 not erased", 5'd4, 16'h0F0F);

        // R8 low programming voltage
        vpp_ok = 1'b0;
        bus_wr(5'd8, 16'h0040);
        bus_wr(5'd8, 16'h0000);
        check("R8 program status", bus_rdata, 16'h0098);
        bus_wr(5'd8, 16'h0050);
        bus_wr(5'd4, 16'h0020);
        bus_wr(5'd4, 16'h00D0);
        check("R8 erase status", bus_rdata, 16'h00A8);
        bus_wr(5'd4, 16'h0050);
        vpp_ok = 1'b1;
        read_arr("R8 word unchanged", 5'd8, 16'hFFFF);
        read_arr("R8 block unchanged", 5'd4, 16'h0F0F);

        // R9 boot block lock
        prot_n = 1'b0;
        bus_wr(5'd25, 16'h0040);
        bus_wr(5'd25, 16'h00AA);
        check("R9 lock status", bus_rdata, 16'h0092);
        bus_wr(5'd25, 16'h0050);
        read_arr("R9 locked word", 5'd25, 16'hFFFF);
        prot_n = 1'b1;
        bus_wr(5'd25, 16'h0040);
        bus_wr(5'd25, 16'h00AA);
        wait_ready(n);
        check("R9 unlocked status", bus_rdata, 16'h0080);
        read_arr("R9 unlocked word", 5'd25, 16'h00AA);

        // R6 R7 program suspend and resume
        bus_wr(5'd12, 16'h0040);
        bus_wr(5'd12, 16'h5555);
        @(negedge clk);
        bus_wr(5'd12, 16'h00B0);
        check("R6 hiz", {15'd0, ry_by_hiz}, 16'd1);
        check("R6 program suspend status", bus_rdata, 16'h0084);
        read_arr("R6 target untouched", 5'd12, 16'hFFFF);
        bus_wr(5'd12, 16'h00D0);
        check("R7 hiz off", {15'd0, ry_by_hiz}, 16'd0);
        check("R7 busy again", {15'd0, ry_by}, 16'd0);
        wait_ready(n);
        read_arr("R7 program done", 5'd12, 16'h5555);

        // R6 R7 erase suspend and resume
        bus_wr(5'd4, 16'h0020);
        bus_wr(5'd4, 16'h00D0);
        @(negedge clk);
        bus_wr(5'd4, 16'h00B0);
        check("R6 erase suspend status", bus_rdata, 16'h00C0);
        read_arr("R6 block untouched", 5'd4, 16'h0F0F);
        read_arr("R6 other block readable", 5'd12, 16'h5555);
        bus_wr(5'd4, 16'h00D0);
        check("R7 erase resumed", {15'd0, ry_by}, 16'd0);
        wait_ready(n);
        read_arr("R7 erase done", 5'd4, 16'hFFFF);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule